// File: doc/BRIEF.md
# Smart Card Waiting-Time Counter

This block supervises the response timing of a smart card attached to a reader. A down-counter (24 bits by default) measures the answer-to-reset window in card clock cycles, or the character and block waiting times in elementary time units (ETUs). Software programs a reload value and an operating mode. The counter then runs freely, arms itself and starts on the next received start bit, or runs until a character arrives. When it runs out, a sticky timeout flag is raised and stays up until software clears it.

A second, small counter enforces the block guard time after each received character. It loads 16 ETUs when the T=0 protocol is selected and 22 ETUs when T=1 is selected. While it is non-zero, the transmitter is held off. The block takes the ETU tick, a card clock tick, the character start and stop strobes and the protocol select from the surrounding UART, which is not part of this block.

Top module: `card_wait_timer`

## Requirements
- R1: After a synchronous active-low reset, `wt_timeout` and `tx_hold` are 0 and the main counter is idle.
- R2: With mode code 1 (free-run) written while the reload value is N ≥ 1, `wt_timeout` stays 0 through the first N−1 counting ticks. It reads 1 in the cycle after the N-th counting tick. Character strobes do not affect this mode.
- R3: The unit bit written with the mode selects the counting tick. 0 selects `etu_tick` and 1 selects `cclk_tick`. Ticks of the unselected source have no effect on the main counter.
- R4: Mode code 2 (start-on-start-bit) arms the counter without counting. Each `char_start` loads the reload value and runs the counter, including a `char_start` that arrives while it is running. After a timeout, the counter re-arms.
- R5: Mode code 3 (stop-on-character) loads the reload value and runs. The first `char_start` stops the counter, and no timeout follows from it.
- R6: A write of `reload_val` does not change a count in progress. It takes effect at the next load event: a mode write of code 1 or 3, or a `char_start` in mode code 2.
- R7: A `char_stop` with `proto_t1`=0 raises `tx_hold`. `tx_hold` stays 1 through 15 further ETU ticks and drops in the cycle after the 16th. A new `char_stop` restarts the full length.
- R8: A `char_stop` with `proto_t1`=1 holds `tx_hold` for 22 ETU ticks. The protocol is taken at the `char_stop` cycle, so a later change of `proto_t1` does not alter that guard period.
- R9: Mode code 0 (off) stops the main counter. No timeout follows until a new mode is written.
- R10: `wt_timeout` is sticky. It stays 1 until `timeout_clr` is pulsed, and a new timeout wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| cclk_tick | input | 1 | One-cycle pulse per card clock cycle |
| char_start | input | 1 | Start bit of a received character detected |
| char_stop | input | 1 | Last bit of a received character completed |
| proto_t1 | input | 1 | 1 selects protocol T=1, 0 selects T=0 |
| reload_wr | input | 1 | Write strobe for the reload value |
| reload_val | input | CNT_W | Reload value to store |
| mode_wr | input | 1 | Write strobe for mode and unit |
| mode_val | input | 2 | Mode code: 0 off, 1 free-run, 2 start-on-start-bit, 3 stop-on-character |
| unit_val | input | 1 | Counting unit: 0 ETU, 1 card clock |
| timeout_clr | input | 1 | Clears the sticky timeout flag |
| wt_timeout | output | 1 | Sticky waiting-time expiry flag |
| tx_hold | output | 1 | Guard time running, transmission held off |

## Verification
The bench builds the block with an 8-bit main counter and keeps the guard lengths at 16 and 22. A narrow counter makes it cheap to sweep every reload value from 1 to 40 in both counting units, checking the tick before and the tick of expiry for each one. Keeping the real guard lengths lets the bench step through every tick of both guard periods. The mode, reload-timing and protocol-sampling corner cases are then driven as short directed sequences, with the expected tick of expiry worked out arithmetically from the programmed value.

// File: rtl/cwt_pkg.sv
// Package: shared encodings for the waiting-time counter.
// Assumes: mode codes are written by software as 2-bit values.
package cwt_pkg;
    typedef enum logic [1:0] {
        MODE_OFF          = 2'd0,
        MODE_FREE         = 2'd1,
        MODE_ON_START     = 2'd2,
        MODE_STOP_ON_CHAR = 2'd3
    } wt_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } wt_state_e;
endpackage

// File: rtl/cwt_config_regs.sv
// Module: holds the software-written reload value, mode and counting unit.
// Assumes: write strobes are single-cycle. A value written here is seen by
// the counter one cycle later, so it never affects a load in the same cycle.
module cwt_config_regs
    import cwt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             mode_wr,
    input  logic [1:0]       mode_val,
    input  logic             unit_val,
    output logic [CNT_W-1:0] shadow_q,
    output wt_mode_e         mode_q,
    output logic             unit_q
);
    // Captures the reload value; a running count is untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (reload_wr) begin
            shadow_q <= reload_val;
        end
    end

    // Captures mode and counting unit together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            unit_q <= 1'b0;
        end else if (mode_wr) begin
            mode_q <= wt_mode_e'(mode_val);
            unit_q <= unit_val;
        end
    end

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_wr |=> $stable(shadow_q));
endmodule

// File: rtl/cwt_main_counter.sv
// Module: waiting-time down-counter with mode-driven load, stop and arm.
// Assumes: tick is already the selected unit and is a one-cycle pulse.
// A mode write has priority over a character strobe, and a load has
// priority over a tick in the same cycle.
module cwt_main_counter
    import cwt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             char_start,
    input  logic             mode_wr,
    input  logic [1:0]       mode_val,
    input  wt_mode_e         mode_q,
    input  logic [CNT_W-1:0] shadow_q,
    input  logic             timeout_clr,
    output logic             timeout_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wt_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             expire;
    wt_mode_e         new_mode;

    assign new_mode = wt_mode_e'(mode_val);

    // Next-state logic: mode writes, strobes, then ticks.
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (mode_wr) begin
            case (new_mode)
                MODE_OFF:      st_d = ST_IDLE;
                MODE_ON_START: st_d = ST_ARMED;
                default: begin
                    cnt_d = shadow_q;
                    st_d  = ST_RUN;
                end
            endcase
        end else if (char_start && mode_q == MODE_ON_START && st_q != ST_IDLE) begin
            cnt_d = shadow_q;
            st_d  = ST_RUN;
        end else if (char_start && mode_q == MODE_STOP_ON_CHAR && st_q == ST_RUN) begin
            st_d = ST_IDLE;
        end else if (st_q == ST_RUN && tick) begin
            if (cnt_q <= ONE) begin
                cnt_d  = '0;
                expire = 1'b1;
                st_d   = (mode_q == MODE_ON_START) ? ST_ARMED : ST_IDLE;
            end else begin
                cnt_d = cnt_q - ONE;
            end
        end
    end

    // State and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Sticky timeout flag; a new expiry beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q <= 1'b0;
        end else if (expire) begin
            timeout_q <= 1'b1;
        end else if (timeout_clr) begin
            timeout_q <= 1'b0;
        end
    end

    assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !mode_wr) |=> $stable(cnt_q));
    assert_no_early_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout_q && cnt_q > ONE) |=> !timeout_q);
    assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_q && !timeout_clr) |=> timeout_q);
    assert_stop_on_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && mode_q == MODE_STOP_ON_CHAR && char_start && !mode_wr)
        |=> (st_q == ST_IDLE && !$rose(timeout_q)));
    assert_armed_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED && !char_start && !mode_wr) |=> st_q == ST_ARMED);
endmodule

// File: rtl/cwt_guard_counter.sv
// Module: block guard counter, loaded on each received character end.
// Assumes: the length is chosen by the protocol select in the char_stop
// cycle and counted down in ETU ticks; a load has priority over a tick.
module cwt_guard_counter #(
    parameter int GUARD_T0 = 16,
    parameter int GUARD_T1 = 22,
    parameter int G_W      = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic etu_tick,
    input  logic char_stop,
    input  logic proto_t1,
    output logic busy
);
    localparam logic [G_W-1:0] LEN_T0 = G_W'(GUARD_T0);
    localparam logic [G_W-1:0] LEN_T1 = G_W'(GUARD_T1);

    logic [G_W-1:0] gcnt_q;

    // Loads the protocol length, then counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt_q <= '0;
        end else if (char_stop) begin
            gcnt_q <= proto_t1 ? LEN_T1 : LEN_T0;
        end else if (etu_tick && gcnt_q != '0) begin
            gcnt_q <= gcnt_q - G_W'(1);
        end
    end

    assign busy = (gcnt_q != '0);

    assert_guard_t0_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stop && !proto_t1) |=> gcnt_q == LEN_T0);
    assert_guard_t1_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stop && proto_t1) |=> gcnt_q == LEN_T1);
    assert_guard_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gcnt_q == '0 && !char_stop) |=> gcnt_q == '0);
endmodule

// File: rtl/card_wait_timer.sv
// Module: top of the smart card waiting-time counter.
// Assumes: all strobes are synchronous single-cycle pulses from the UART
// side. Ties the configuration registers, tick selection, main waiting
// counter and block guard counter together.
module card_wait_timer
    import cwt_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int GUARD_T0 = 16,
    parameter int GUARD_T1 = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             etu_tick,
    input  logic             cclk_tick,
    input  logic             char_start,
    input  logic             char_stop,
    input  logic             proto_t1,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             mode_wr,
    input  logic [1:0]       mode_val,
    input  logic             unit_val,
    input  logic             timeout_clr,
    output logic             wt_timeout,
    output logic             tx_hold
);
    localparam int GUARD_MAX = (GUARD_T1 > GUARD_T0) ? GUARD_T1 : GUARD_T0;
    localparam int G_W       = $clog2(GUARD_MAX + 1);

    logic [CNT_W-1:0] shadow_q;
    wt_mode_e         mode_q;
    logic             unit_q;
    logic             count_tick;

    cwt_config_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_wr  (reload_wr),
        .reload_val (reload_val),
        .mode_wr    (mode_wr),
        .mode_val   (mode_val),
        .unit_val   (unit_val),
        .shadow_q   (shadow_q),
        .mode_q     (mode_q),
        .unit_q     (unit_q)
    );

    // Selects the counting unit for the main counter.
    always_comb begin
        count_tick = unit_q ? cclk_tick : etu_tick;
    end

    cwt_main_counter #(.CNT_W(CNT_W)) u_main (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (count_tick),
        .char_start  (char_start),
        .mode_wr     (mode_wr),
        .mode_val    (mode_val),
        .mode_q      (mode_q),
        .shadow_q    (shadow_q),
        .timeout_clr (timeout_clr),
        .timeout_q   (wt_timeout)
    );

    cwt_guard_counter #(
        .GUARD_T0 (GUARD_T0),
        .GUARD_T1 (GUARD_T1),
        .G_W      (G_W)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .etu_tick  (etu_tick),
        .char_stop (char_stop),
        .proto_t1  (proto_t1),
        .busy      (tx_hold)
    );

    assert_unit_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wt_timeout && !count_tick) |=> !wt_timeout);
endmodule

// File: tb/sim_card_wait_timer.sv
// Bench: sweeps reload values in both units and every guard tick, then
// directed mode sequences. Inputs change at the falling edge, checks are
// made at the falling edge after the rising edge that registered them.
module sim_card_wait_timer;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          etu_tick = 0, cclk_tick = 0, char_start = 0, char_stop = 0;
    logic          proto_t1 = 0, reload_wr = 0, mode_wr = 0, unit_val = 0;
    logic          timeout_clr = 0;
    logic [CW-1:0] reload_val = '0;
    logic [1:0]    mode_val = 2'd0;
    logic          wt_timeout, tx_hold;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    card_wait_timer #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .cclk_tick(cclk_tick),
        .char_start(char_start), .char_stop(char_stop), .proto_t1(proto_t1),
        .reload_wr(reload_wr), .reload_val(reload_val), .mode_wr(mode_wr),
        .mode_val(mode_val), .unit_val(unit_val), .timeout_clr(timeout_clr),
        .wt_timeout(wt_timeout), .tx_hold(tx_hold)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One tick of the chosen source followed by one quiet cycle.
    task automatic tick(input bit use_cclk, input int n);
        for (int i = 0; i < n; i++) begin
            if (use_cclk) cclk_tick = 1; else etu_tick = 1;
            @(negedge clk);
            cclk_tick = 0;
            etu_tick = 0;
            @(negedge clk);
        end
    endtask

    task automatic set_reload(input int v);
        reload_wr = 1; reload_val = CW'(v);
        @(negedge clk);
        reload_wr = 0;
    endtask

    task automatic set_mode(input int m, input bit u);
        mode_wr = 1; mode_val = 2'(m); unit_val = u;
        @(negedge clk);
        mode_wr = 0;
    endtask

    task automatic clr();
        timeout_clr = 1;
        @(negedge clk);
        timeout_clr = 0;
    endtask

    task automatic start_bit();
        char_start = 1;
        @(negedge clk);
        char_start = 0;
    endtask

    task automatic stop_bit();
        char_stop = 1;
        @(negedge clk);
        char_stop = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        check(wt_timeout, 1'b0, "R1 timeout after reset");
        check(tx_hold, 1'b0, "R1 tx_hold after reset");
        rst_n = 1;
        idle(2);
        check(wt_timeout, 1'b0, "R1 idle after reset release");

        // R2, R3: sweep reload values in both units
        for (int u = 0; u < 2; u++) begin
            for (int n = 1; n <= 40; n++) begin
                clr();
                set_reload(n);
                set_mode(1, u[0]);
                tick(u[0], n - 1);
                start_bit();
                tick(!u[0], 5);
                check(wt_timeout, 1'b0, "R3 other unit ignored / R2 before expiry");
                tick(u[0], 1);
                check(wt_timeout, 1'b1, "R2 expiry on Nth tick");
            end
        end

        // R10: sticky and clear
        tick(0, 10);
        check(wt_timeout, 1'b1, "R10 flag sticky");
        clr();
        check(wt_timeout, 1'b0, "R10 flag cleared");

        // R10: expiry beats clear in the same cycle
        set_reload(1);
        set_mode(1, 0);
        etu_tick = 1; timeout_clr = 1;
        @(negedge clk);
        etu_tick = 0; timeout_clr = 0;
        check(wt_timeout, 1'b1, "R10 set wins over clear");
        clr();

        // R4: arm, start, restart on each start bit, re-arm after expiry
        set_reload(6);
        set_mode(2, 0);
        tick(0, 20);
        check(wt_timeout, 1'b0, "R4 armed does not count");
        start_bit();
        tick(0, 5);
        check(wt_timeout, 1'b0, "R4 running before expiry");
        start_bit();
        tick(0, 5);
        check(wt_timeout, 1'b0, "R4 start bit reloads");
        tick(0, 1);
        check(wt_timeout, 1'b1, "R4 expiry after reload");
        clr();
        tick(0, 20);
        check(wt_timeout, 1'b0, "R4 re-armed waits");
        start_bit();
        tick(0, 6);
        check(wt_timeout, 1'b1, "R4 re-armed expiry");
        clr();

        // R5: stop on character
        set_reload(6);
        set_mode(3, 0);
        tick(0, 5);
        start_bit();
        tick(0, 20);
        check(wt_timeout, 1'b0, "R5 stopped by character");

        // R6: reload write during a run waits for the next load
        set_reload(10);
        set_mode(1, 0);
        tick(0, 3);
        set_reload(4);
        tick(0, 6);
        check(wt_timeout, 1'b0, "R6 old value still counting");
        tick(0, 1);
        check(wt_timeout, 1'b1, "R6 expiry at old value");
        clr();
        set_mode(1, 0);
        tick(0, 3);
        check(wt_timeout, 1'b0, "R6 new value before expiry");
        tick(0, 1);
        check(wt_timeout, 1'b1, "R6 new value used at load");
        clr();

        // R9: mode off stops a running count
        set_reload(5);
        set_mode(1, 0);
        tick(0, 2);
        set_mode(0, 0);
        tick(0, 20);
        check(wt_timeout, 1'b0, "R9 off stops counting");

        // R7, R8: every tick of both guard lengths
        for (int p = 0; p < 2; p++) begin
            int len;
            len = p ? 22 : 16;
            proto_t1 = p[0];
            stop_bit();
            if (p == 1) proto_t1 = 0;
            check(tx_hold, 1'b1, p ? "R8 hold on stop" : "R7 hold on stop");
            for (int k = 1; k <= len; k++) begin
                tick(0, 1);
                check(tx_hold, (k < len), p ? "R8 guard tick" : "R7 guard tick");
            end
        end

        // R7: restart of guard by a new character end
        proto_t1 = 0;
        stop_bit();
        tick(0, 10);
        stop_bit();
        tick(0, 15);
        check(tx_hold, 1'b1, "R7 restart full length");
        tick(0, 1);
        check(tx_hold, 1'b0, "R7 restart ends");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule